// File: doc/BRIEF.md
# Fractional Multiplier with Output Shift

A signed fractional fixed-point multiply unit for a narrow DSP datapath. Two Q15 operands are multiplied to a full double-width product, and an instruction-selected shift is applied to that product before it is cut down to the output word. A separate shift instruction after an ordinary fractional multiply would only see the already-narrowed word and would lose the low bits. This unit keeps them, and one operation does the work of two.

The option-count parameter fixes the set of shifts at elaboration: eight options (4 left to 3 right), four options (2 left to 1 right) or two options (1 left or none). The select field holds a two's-complement code c, and the left shift applied is c+1. A negative total means a right shift. When the result does not fit in the output word, it saturates to the nearest extreme and an overflow flag is set. A single register stage sits between the inputs and the outputs.

Top module: `frac_mul_shift`

## Requirements
- R1: With 8 options, code 3'b111 (c = -1) applies no shift, and the result is bits [30:15] of the 32-bit signed product of the two operands.
- R2: For codes 3'b000..3'b011 the result equals floor(A*B*2^(c+1) / 2^15), so product bits below bit 15 move into the result rather than being dropped as zeros.
- R3: Codes 3'b100..3'b110 shift right by 3, 2 and 1 bits. The shift is arithmetic, and the narrowed value is truncated toward negative infinity.
- R4: When the shifted value exceeds the output range, the result saturates to 16'h7FFF (positive) or 16'h8000 (negative) and the overflow flag is set in that output cycle. Otherwise the overflow flag is low.
- R5: The product of 16'h8000 with 16'h8000 with no left shift or a left shift gives 16'h7FFF with overflow set.
- R6: The output valid flag equals the input valid of the previous clock. Result and overflow belong to the operation launched in that previous cycle.
- R7: While reset is high at a clock edge, the output valid, the overflow flag and the result are cleared to zero.
- R8: A cycle with input valid low leaves the result unchanged and drives overflow low in the following cycle.
- R9: With 2 options the 1-bit code 1 applies no shift and code 0 shifts left by one, following the same rule of c+1 for a signed code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation strobe |
| op_a | input | W | Q15 multiplicand |
| op_b | input | W | Q15 multiplier |
| sh_sel | input | log2(NOPT) | Signed shift code, left amount = code+1 |
| out_vld | output | 1 | Result valid, one clock after in_vld |
| res | output | W | Shifted, saturated product |
| ovf | output | 1 | Saturation occurred |

## Verification
The bench goes after the extreme shift codes. A design that mapped the code wrongly would put the binary point in the wrong place, and a design that shifted after narrowing would zero the low bits that a left shift should bring in. Right shifts of small negative products are checked to land on -1 and not 0, which catches a logical shift or rounding toward zero. The square of -1.0 and large products shifted left must saturate on the correct side with overflow raised. A wrapping design would give 16'h8000 or a flipped sign. Idle cycles and a second instance with the two-option set check that the result holds and that the code is decoded for the narrow select field.

// File: rtl/frac_mul_shift.sv
`timescale 1ns/1ps
module frac_mul_shift #(
  parameter int W    = 16,
  parameter int NOPT = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_vld,
  input  logic [W-1:0]              op_a,
  input  logic [W-1:0]              op_b,
  input  logic [$clog2(NOPT)-1:0]   sh_sel,
  output logic                      out_vld,
  output logic [W-1:0]              res,
  output logic                      ovf
);
  localparam int SW = $clog2(NOPT);
  localparam int PW = 2 * W;
  localparam int RW = $clog2(PW) + 2;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] prod, shf;
  logic signed [SW:0]   lsh;
  logic signed [RW-1:0] rsh;
  logic                 ovf_d;
  logic [W-1:0]         sat_d;

  assign prod  = $signed(op_a) * $signed(op_b);
  assign lsh   = $signed({sh_sel[SW-1], sh_sel}) + $signed({{SW{1'b0}}, 1'b1});
  assign rsh   = RW'(W - 1) - RW'(lsh);
  assign shf   = prod >>> rsh[RW-2:0];
  assign ovf_d = (|shf[PW-1:W-1]) & ~(&shf[PW-1:W-1]);
  assign sat_d = ovf_d ? (shf[PW-1] ? NEG_MAX : POS_MAX) : shf[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      ovf     <= 1'b0;
      res     <= '0;
    end else begin
      out_vld <= in_vld;
      ovf     <= in_vld & ovf_d;
      if (in_vld) res <= sat_d;
    end
  end

  // R6
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (out_vld == $past(in_vld)));

  // R8
  ovf_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |-> out_vld);

  // R4
  ovf_sat_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (res == POS_MAX || res == NEG_MAX));

  // R5
  negone_sq_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op_a == NEG_MAX && op_b == NEG_MAX && !lsh[SW]) |=> (ovf && res == POS_MAX));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !in_vld |=> $stable(res));
endmodule

// File: tb/test_frac_mul_shift.sv
`timescale 1ns/1ps
module test_frac_mul_shift;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [2:0]  sh_sel = '0;
  logic        sh2 = 1'b0;
  logic        out_vld, ovf, out_vld2, ovf2;
  logic [15:0] res, res2;

  int tests = 0, fails = 0;
  logic        e_vld = 0, e_ovf = 0, e_vld2 = 0, e_ovf2 = 0;
  logic [15:0] e_res = 0, e_res2 = 0;
  string       e_tag = "R7";

  always #5 clk = ~clk;

  frac_mul_shift #(.W(16), .NOPT(8)) i_frac_mul_shift (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .sh_sel(sh_sel), .out_vld(out_vld), .res(res), .ovf(ovf));

  frac_mul_shift #(.W(16), .NOPT(2)) i_frac_mul_shift_n2 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .sh_sel(sh2), .out_vld(out_vld2), .res(res2), .ovf(ovf2));

  task automatic model(input logic [15:0] a, input logic [15:0] b, input int l,
                       output logic [15:0] r, output logic o);
    longint p, v;
    p = longint'($signed(a)) * longint'($signed(b));
    v = (p <<< 8) >>> (23 - l);
    o = 1'b0;
    if (v > 32767) begin r = 16'h7FFF; o = 1'b1; end
    else if (v < -32768) begin r = 16'h8000; o = 1'b1; end
    else r = 16'(v);
  endtask

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(e_tag, "out_vld", out_vld, e_vld);
    chk(e_tag, "res", res, e_res);
    chk(e_tag, "ovf", ovf, e_ovf);
    chk("R9", "out_vld2", out_vld2, e_vld2);
    chk("R9", "res2", res2, e_res2);
    chk("R9", "ovf2", ovf2, e_ovf2);
  endtask

  task automatic cyc(input string tag, input logic v, input logic [15:0] a,
                     input logic [15:0] b, input logic [2:0] s, input logic s2);
    logic [15:0] r;
    logic o;
    @(negedge clk);
    compare();
    in_vld = v; op_a = a; op_b = b; sh_sel = s; sh2 = s2;
    e_tag = tag;
    e_vld = v; e_vld2 = v;
    if (v) begin
      model(a, b, int'($signed(s)) + 1, r, o);
      e_res = r; e_ovf = o;
      model(a, b, s2 ? 0 : 1, r, o);
      e_res2 = r; e_ovf2 = o;
    end else begin
      e_ovf = 1'b0; e_ovf2 = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_tag = "R7";
    compare();
    rst = 1'b0;
    cyc("R1", 1, 16'h4000, 16'h4000, 3'b111, 1'b1);
    cyc("R1", 1, 16'hC000, 16'h2000, 3'b111, 1'b0);
    cyc("R2", 1, 16'h0123, 16'h0456, 3'b011, 1'b0);
    cyc("R2", 1, 16'h0123, 16'hF456, 3'b010, 1'b0);
    cyc("R2", 1, 16'h00FF, 16'h0081, 3'b000, 1'b0);
    cyc("R3", 1, 16'hFFFF, 16'h0001, 3'b100, 1'b1);
    cyc("R3", 1, 16'h8000, 16'h4000, 3'b100, 1'b1);
    cyc("R3", 1, 16'h7FFF, 16'hFFFD, 3'b101, 1'b1);
    cyc("R3", 1, 16'h1234, 16'h5678, 3'b110, 1'b0);
    cyc("R4", 1, 16'h4000, 16'h4000, 3'b011, 1'b0);
    cyc("R4", 1, 16'h8000, 16'h7FFF, 3'b000, 1'b0);
    cyc("R5", 1, 16'h8000, 16'h8000, 3'b111, 1'b1);
    cyc("R5", 1, 16'h8000, 16'h8000, 3'b001, 1'b0);
    cyc("R5", 1, 16'h8000, 16'h8000, 3'b100, 1'b1);
    cyc("R8", 0, 16'h7FFF, 16'h7FFF, 3'b011, 1'b0);
    cyc("R8", 0, 16'h8000, 16'h8000, 3'b011, 1'b0);
    cyc("R6", 1, 16'h2000, 16'h2000, 3'b111, 1'b1);
    for (int i = 0; i < 500; i++) begin
      cyc("R6", ($urandom % 4) != 0, 16'($urandom), 16'($urandom),
          3'($urandom), 1'($urandom));
    end
    cyc("R8", 0, 16'h0, 16'h0, 3'b0, 1'b0);
    cyc("R6", 0, 16'h0, 16'h0, 3'b0, 1'b0);
    @(negedge clk);
    compare();
    rst = 1'b1;
    @(negedge clk);
    e_tag = "R7";
    e_vld = 0; e_ovf = 0; e_res = 0; e_vld2 = 0; e_ovf2 = 0; e_res2 = 0;
    compare();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule